// File: doc/BRIEF.md
# Two-Bit Branch History Table

This block is a direct-mapped table of saturating two-bit counters that guesses whether a conditional branch will be taken. The fetch stage presents the address of the instruction it is fetching. In the same cycle, with no clock edge in between, the block answers with a taken or not-taken guess. The guess is read from the entry selected by a few low-order address bits.

Later in the pipeline a branch resolves. The resolving stage then presents that branch's address and its real outcome on a separate update port. The selected counter moves one step toward the real outcome and stops at either end. Because the counter has two bits, a strongly biased entry needs two wrong guesses in a row before its guess flips. Target addresses and pipeline control are outside this block.

Top module: `branch_hist_table`

## Requirements
- R1: After reset every entry holds weakly not-taken (state 01), so a lookup at any address predicts not-taken (`lk_taken` = 0).
- R2: The entry index is address bits [7:2] (64 entries). Addresses that differ only in bits [1:0] or in bits above 7 select the same entry.
- R3: The prediction is the most significant bit of the selected state. The states are 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken.
- R4: An update with a taken outcome raises the entry's state by one and holds it at 11.
- R5: An update with a not-taken outcome lowers the entry's state by one and holds it at 00.
- R6: From a strong state, one opposite outcome leaves the prediction unchanged. A second consecutive opposite outcome flips it.
- R7: When `upd_valid` is 0 no entry changes, whatever `upd_addr` and `upd_taken` carry.
- R8: An update changes only the entry selected by `upd_addr`.
- R9: If a lookup and an update select the same entry in one cycle, the lookup returns the state from before the update. The new state is seen from the next cycle on.
- R10: The lookup is combinational. `lk_taken` follows `lk_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| lk_addr | input | 32 | Address of the instruction being fetched |
| lk_taken | output | 1 | Prediction for `lk_addr`: 1 = taken |
| upd_valid | input | 1 | A branch has resolved this cycle |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch: 1 = taken |

## Verification
A lookup and an update can fall in the same cycle, and both can select the same entry. This case is set up on purpose with directed steps. In one step the update and the lookup use equal addresses. In another step their addresses differ only in bits outside [7:2]. The random phase also limits addresses to a few indices, so such collisions happen often. The bench samples the prediction just before the clock edge and compares it with the old state held in its own model. The step after the edge must then show the new state.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_t;

  localparam ctr_t CTR_RESET = CTR_WEAK_NT;

  // One step toward the resolved outcome, held at both ends.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken && cur != CTR_STRONG_T)
      nxt = ctr_t'(cur + 2'b01);
    else if (!taken && cur != CTR_STRONG_NT)
      nxt = ctr_t'(cur - 2'b01);
    return nxt;
  endfunction

  function automatic logic ctr_guess(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 6,
  parameter int ALIGN_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  always_comb idx = IDX_W'(addr >> ALIGN_LSB);
endmodule

// File: rtl/bht_store.sv
module bht_store
  import bht_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  ctr_t                   wr_state,
  input  logic [IDX_W-1:0]       rd_a_idx,
  output ctr_t                   rd_a_state,
  input  logic [IDX_W-1:0]       rd_b_idx,
  output ctr_t                   rd_b_state,
  output logic [2*ENTRIES-1:0]   state_flat
);
  ctr_t ent_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q[e] <= CTR_RESET;
      else if (wr_en && wr_idx == IDX_W'(e))
        ent_q[e] <= wr_state;
    end
    assign state_flat[2*e +: 2] = ent_q[e];
  end

  always_comb rd_a_state = ent_q[rd_a_idx];
  always_comb rd_b_state = ent_q[rd_b_idx];
endmodule

// File: rtl/branch_hist_table.sv
module branch_hist_table
  import bht_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 6,
  parameter int ALIGN_LSB = 2,
  localparam int ENTRIES  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_taken,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken
);
  logic [IDX_W-1:0]     lk_idx;
  logic [IDX_W-1:0]     upd_idx;
  ctr_t                 lk_state;
  ctr_t                 upd_old_state;
  ctr_t                 upd_new_state;
  logic [2*ENTRIES-1:0] state_flat;

  bht_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_LSB(ALIGN_LSB)) u_lk_index (
    .addr (lk_addr),
    .idx  (lk_idx)
  );

  bht_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_LSB(ALIGN_LSB)) u_upd_index (
    .addr (upd_addr),
    .idx  (upd_idx)
  );

  bht_store #(.IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (upd_valid),
    .wr_idx     (upd_idx),
    .wr_state   (upd_new_state),
    .rd_a_idx   (lk_idx),
    .rd_a_state (lk_state),
    .rd_b_idx   (upd_idx),
    .rd_b_state (upd_old_state),
    .state_flat (state_flat)
  );

  always_comb upd_new_state = ctr_step(upd_old_state, upd_taken);
  always_comb lk_taken      = ctr_guess(lk_state);
endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
  parameter int IDX_W = 6,
  localparam int ENTRIES = 1 << IDX_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 upd_valid,
  input logic                 upd_taken,
  input logic [IDX_W-1:0]     upd_idx,
  input logic [IDX_W-1:0]     lk_idx,
  input logic                 lk_taken,
  input logic [2*ENTRIES-1:0] state_flat
);
  function automatic logic [1:0] ent(input logic [2*ENTRIES-1:0] f, input logic [IDX_W-1:0] i);
    return f[2*i +: 2];
  endfunction

  function automatic logic [2*ENTRIES-1:0] keep_mask(input logic [IDX_W-1:0] i);
    logic [2*ENTRIES-1:0] m;
    m = '1;
    m[2*i +: 2] = 2'b00;
    return m;
  endfunction

  AST_PRED_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken == ent(state_flat, lk_idx)[1]); // R3

  AST_TAKEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      ent(state_flat, $past(upd_idx)) ==
      ((ent($past(state_flat), $past(upd_idx)) == 2'b11) ? 2'b11
        : ent($past(state_flat), $past(upd_idx)) + 2'b01)); // R4

  AST_NOTTAKEN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=>
      ent(state_flat, $past(upd_idx)) ==
      ((ent($past(state_flat), $past(upd_idx)) == 2'b00) ? 2'b00
        : ent($past(state_flat), $past(upd_idx)) - 2'b01)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(state_flat)); // R7

  AST_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ((state_flat ^ $past(state_flat)) & keep_mask($past(upd_idx))) == '0); // R8
endmodule

bind branch_hist_table bht_checker #(.IDX_W(IDX_W)) u_bht_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_valid  (upd_valid),
  .upd_taken  (upd_taken),
  .upd_idx    (upd_idx),
  .lk_idx     (lk_idx),
  .lk_taken   (lk_taken),
  .state_flat (state_flat)
);

// File: tb/branch_hist_table_bench.sv
`timescale 1ns/1ps
module branch_hist_table_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_addr = '0;
  logic        upd_taken = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic [1:0] model [64];

  always #4 clk = ~clk;

  branch_hist_table u_branch_hist_table (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_taken(lk_taken),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken)
  );

  function automatic int slot(input logic [31:0] a);
    return int'((a / 4) % 64);
  endfunction

  function automatic logic [1:0] moved(input logic [1:0] s, input logic t);
    if (t) return (s == 2'd3) ? 2'd3 : s + 2'd1;
    return (s == 2'd0) ? 2'd0 : s - 2'd1;
  endfunction

  task automatic judge(input logic got, input logic want, input string tag);
    n_checks++;
    if (got !== want) begin
      n_fails++;
      $display("FAIL %s: lk_taken=%0b expected %0b at t=%0t", tag, got, want, $time);
    end
  endtask

  // One cycle: drive, check the combinational guess before the edge, advance the model.
  task automatic step(input logic uv, input logic [31:0] ua, input logic ut,
                      input logic [31:0] la, input string tag);
    @(negedge clk);
    upd_valid = uv; upd_addr = ua; upd_taken = ut; lk_addr = la;
    #1;
    judge(lk_taken, model[slot(la)][1], tag);
    if (uv) model[slot(ua)] = moved(model[slot(ua)], ut);
  endtask

  // Directed lookup with an explicitly stated expectation, no update.
  task automatic probe(input logic [31:0] la, input logic want, input string tag);
    @(negedge clk);
    upd_valid = 1'b0; lk_addr = la;
    #1;
    judge(lk_taken, want, tag);
  endtask

  task automatic train(input logic [31:0] ua, input logic ut);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = ua; upd_taken = ut; lk_addr = 32'h0;
    model[slot(ua)] = moved(model[slot(ua)], ut);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    for (int i = 0; i < 64; i++) model[i] = 2'b01;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state is weakly not-taken everywhere
    probe(32'h0000_0000, 1'b0, "R1 reset idx0");
    probe(32'h0000_00FC, 1'b0, "R1 reset idx63");
    probe(32'h1234_5678, 1'b0, "R1 reset random addr");

    // R3/R4: 01 -> 10 -> 11 -> 11 (saturate)
    train(32'h40, 1'b1);
    probe(32'h40, 1'b1, "R3 weak taken predicts taken");
    train(32'h40, 1'b1);
    train(32'h40, 1'b1);
    // R6: one not-taken from strong taken keeps the guess (also catches a 11->00 wrap, R4)
    train(32'h40, 1'b0);
    probe(32'h40, 1'b1, "R6 R4 one miss keeps taken");
    train(32'h40, 1'b0);
    probe(32'h40, 1'b0, "R6 second miss flips");
    // R5: down to 00 and hold, then one taken reaches only 01
    train(32'h40, 1'b0);
    train(32'h40, 1'b0);
    train(32'h40, 1'b0);
    train(32'h40, 1'b1);
    probe(32'h40, 1'b0, "R5 saturated at strong not-taken");
    train(32'h40, 1'b1);
    probe(32'h40, 1'b1, "R5 two taken reach weak taken");

    // R2: aliasing on bits outside [7:2]
    probe(32'h0000_0043, 1'b1, "R2 low bits ignored");
    probe(32'hABCD_0140, 1'b1, "R2 high bits ignored");
    probe(32'h0000_0044, 1'b0, "R2 next index distinct");

    // R8: training index 17 leaves index 16 alone
    train(32'h44, 1'b1);
    train(32'h44, 1'b1);
    probe(32'h44, 1'b1, "R8 neighbour trained");
    train(32'h40, 1'b0);
    probe(32'h40, 1'b0, "R8 own entry moves");
    probe(32'h44, 1'b1, "R8 neighbour untouched");

    // R7: invalid updates do nothing
    @(negedge clk);
    upd_valid = 1'b0; upd_addr = 32'h14; upd_taken = 1'b1;
    @(negedge clk);
    @(negedge clk);
    probe(32'h14, 1'b0, "R7 invalid update ignored");

    // R9/R10: same-cycle lookup sees old state, next cycle sees new
    step(1'b1, 32'h50, 1'b1, 32'h50, "R9 same cycle old value");
    step(1'b0, 32'h0, 1'b0, 32'h50, "R9 new value next cycle");
    step(1'b1, 32'h58, 1'b1, 32'hF000_005B, "R9 R2 alias same cycle");
    step(1'b0, 32'h0, 1'b0, 32'h58, "R10 lookup follows addr");
    step(1'b0, 32'h0, 1'b0, 32'h5C, "R10 lookup follows addr");

    // Random phase against the model, addresses folded onto few indices
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] ua, la;
      ua = ($urandom() & 32'hFFFF_FF03) | (32'(($urandom() % 6) + 16) << 2);
      la = ($urandom() & 32'hFFFF_FF03) | (32'(($urandom() % 6) + 16) << 2);
      step(1'($urandom() % 4 != 0), ua, 1'($urandom()), la, "R3 R4 R5 R9 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule